// File: doc/BRIEF.md
# Configurable PAL Output Macrocell Bank

This block is the output stage of a sum-of-products logic device. Each cell takes the sum term that the AND/OR array produces for it, plus an output-enable term and the value seen on its pin. It then drives the pin, gates the pin buffer and returns a feedback bit to the array. Four configuration bits per cell choose the behaviour. The output can come straight from the sum term or from a D flip-flop. The output polarity can be set to either sense. The flip-flop can be clocked from either of two clocks. The feedback can come from the flip-flop or from the pin.

All cells in the bank share the two clocks, an asynchronous clear term, a synchronous preset term, a preload strobe and a security lock. The preload strobe lets a tester place any state into the flip-flops directly. The security lock disables preload. Clear and preset act on the flip-flop state only, and the pin shows that state through the selected polarity. A configuration bit that has not been programmed reads as 1. A cell that is left unprogrammed is therefore a combinational, active-high output with pin feedback, clocked from clock A.

Configuration bits for cell `i` sit at `cfgBits[4*i+3 : 4*i]`. Bit 0 selects polarity, bit 1 bypasses the register, bit 2 selects the clock and bit 3 swaps the feedback choice.

Top module: `macrocell_bank`

## Requirements
- R1: With cfg bit 1 = 1 the cell is combinational: `pinDrive` follows `sumTerm` in the same cycle, through the polarity of R3.
- R2: With cfg bit 1 = 0 the cell is registered: `pinDrive` shows the flip-flop state through the polarity of R3. With no clear, preset or preload, the flip-flop loads `sumTerm` on the rising edge of its clock.
- R3: cfg bit 0 = 1 makes the output active high (no inversion). cfg bit 0 = 0 makes it active low (inverted). This holds for both registered and combinational outputs.
- R4: cfg bit 2 = 1 clocks the flip-flop from `clkA`, and cfg bit 2 = 0 clocks it from `clkB`. A rising edge on the clock that is not selected leaves the state unchanged.
- R5: `arrayFeedback` is the pin value `pinIn` when cfg bit 3 equals cfg bit 1. Otherwise it is the flip-flop state.
- R6: `powerUpRst` or `asyncClear` forces the flip-flop LOW at once, without waiting for a clock. A registered active-low cell then drives HIGH, and a registered active-high cell drives LOW.
- R7: `syncPreset` high loads HIGH into the flip-flop on the next rising edge of its selected clock.
- R8: If `asyncClear` and `syncPreset` are high together, the clear wins and the flip-flop stays LOW across clock edges.
- R9: `preloadStrobe` high with `secureLock` low loads `preloadData[i]` on the next selected clock edge. This takes priority over preset and the sum term.
- R10: With `secureLock` high, `preloadStrobe` has no effect, and the flip-flop takes its preset or sum-term value instead.
- R11: `pinEnable` follows `oeTerm`. A cell with `oeTerm` low and pin feedback selected passes `pinIn` to `arrayFeedback` and works as a dedicated input.
- R12: The all-ones configuration 4'b1111 gives a combinational, active-high output with pin feedback.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clkA | input | 1 | First clock, selected by cfg bit 2 = 1 |
| clkB | input | 1 | Second clock, selected by cfg bit 2 = 0 |
| powerUpRst | input | 1 | Power-up reset, active high, clears all flip-flops asynchronously |
| asyncClear | input | 1 | Global asynchronous clear term, active high |
| syncPreset | input | 1 | Global synchronous preset term, active high |
| preloadStrobe | input | 1 | Loads preloadData into the flip-flops on the next selected edge |
| secureLock | input | 1 | Blocks preload when high |
| cfgBits | input | 4*CELLS | Four configuration bits per cell |
| sumTerm | input | CELLS | Sum-of-products input per cell |
| oeTerm | input | CELLS | Output-enable product term per cell |
| pinIn | input | CELLS | Value sensed on each pin |
| preloadData | input | CELLS | Preload value per cell |
| pinDrive | output | CELLS | Value driven toward each pin |
| pinEnable | output | CELLS | Output-buffer enable per cell |
| arrayFeedback | output | CELLS | Feedback bit returned to the array per cell |

## Verification
The bench builds the bank with CELLS = 3. Three cells are enough to hold a clock-A registered cell, a clock-B registered cell and a combinational cell at the same moment, so each global term (clear, preset, preload, lock) can be watched acting on both clock domains and on a bypassed cell together. Configurations are redrawn only while the clear is held. All sixteen configuration codes then appear across the three cells, so every polarity, clock and feedback combination meets random sum-term, pin and enable traffic.

// File: rtl/macrocell_pkg.sv
`timescale 1ns/1ps
package macrocell_pkg;
  localparam int CFG_BITS   = 4;
  localparam int BIT_POL    = 0;
  localparam int BIT_BYPASS = 1;
  localparam int BIT_CLKSEL = 2;
  localparam int BIT_FBSWAP = 3;

  typedef struct packed {
    logic bypass;
    logic activeHigh;
    logic useClkA;
    logic fbFromReg;
  } cellMode_t;

  typedef struct packed {
    logic clearNow;
    logic takePreload;
    logic takePreset;
  } cellStrobe_t;
endpackage

// File: rtl/macrocell_ctrl.sv
`timescale 1ns/1ps
module macrocell_ctrl
  import macrocell_pkg::*;
(
  input  logic [CFG_BITS-1:0] cfgNibble,
  input  logic                powerUpRst,
  input  logic                asyncClear,
  input  logic                syncPreset,
  input  logic                preloadStrobe,
  input  logic                secureLock,
  output cellMode_t           mode,
  output cellStrobe_t         strobe
);
  always_comb begin
    mode.bypass     = cfgNibble[BIT_BYPASS];
    mode.activeHigh = cfgNibble[BIT_POL];
    mode.useClkA    = cfgNibble[BIT_CLKSEL];
    // swap bit set: register feedback only for registered outputs
    mode.fbFromReg  = cfgNibble[BIT_FBSWAP] ? ~cfgNibble[BIT_BYPASS]
                                            :  cfgNibble[BIT_BYPASS];
  end

  always_comb begin
    strobe.clearNow    = powerUpRst | asyncClear;
    strobe.takePreload = preloadStrobe & ~secureLock;
    strobe.takePreset  = syncPreset;
  end
endmodule

// File: rtl/macrocell_datapath.sv
`timescale 1ns/1ps
module macrocell_datapath
  import macrocell_pkg::*;
(
  input  logic        clkA,
  input  logic        clkB,
  input  cellMode_t   mode,
  input  cellStrobe_t strobe,
  input  logic        sumTerm,
  input  logic        oeTerm,
  input  logic        pinIn,
  input  logic        preloadData,
  output logic        pinDrive,
  output logic        pinEnable,
  output logic        arrayFeedback
);
  logic cellClk;
  logic clearNow;
  logic stateQ;
  logic preInvert;

  assign cellClk  = mode.useClkA ? clkA : clkB;
  assign clearNow = strobe.clearNow;

  always_ff @(posedge cellClk or posedge clearNow) begin
    if (clearNow)                stateQ <= 1'b0;
    else if (strobe.takePreload) stateQ <= preloadData;
    else if (strobe.takePreset)  stateQ <= 1'b1;
    else                         stateQ <= sumTerm;
  end

  assign preInvert     = mode.bypass ? sumTerm : stateQ;
  assign pinDrive      = mode.activeHigh ? preInvert : ~preInvert;
  assign pinEnable     = oeTerm;
  assign arrayFeedback = mode.fbFromReg ? stateQ : pinIn;
endmodule

// File: rtl/macrocell_bank.sv
`timescale 1ns/1ps
module macrocell_bank
  import macrocell_pkg::*;
#(
  parameter int CELLS = 4
) (
  input  logic                      clkA,
  input  logic                      clkB,
  input  logic                      powerUpRst,
  input  logic                      asyncClear,
  input  logic                      syncPreset,
  input  logic                      preloadStrobe,
  input  logic                      secureLock,
  input  logic [CELLS*CFG_BITS-1:0] cfgBits,
  input  logic [CELLS-1:0]          sumTerm,
  input  logic [CELLS-1:0]          oeTerm,
  input  logic [CELLS-1:0]          pinIn,
  input  logic [CELLS-1:0]          preloadData,
  output logic [CELLS-1:0]          pinDrive,
  output logic [CELLS-1:0]          pinEnable,
  output logic [CELLS-1:0]          arrayFeedback
);
  localparam int CFG_W = CELLS * CFG_BITS;

  for (genvar i = 0; i < CELLS; i++) begin : g_cell
    cellMode_t   mode;
    cellStrobe_t strobe;

    macrocell_ctrl u_ctrl (
      .cfgNibble    (cfgBits[i*CFG_BITS +: CFG_BITS]),
      .powerUpRst   (powerUpRst),
      .asyncClear   (asyncClear),
      .syncPreset   (syncPreset),
      .preloadStrobe(preloadStrobe),
      .secureLock   (secureLock),
      .mode         (mode),
      .strobe       (strobe)
    );

    macrocell_datapath u_dp (
      .clkA         (clkA),
      .clkB         (clkB),
      .mode         (mode),
      .strobe       (strobe),
      .sumTerm      (sumTerm[i]),
      .oeTerm       (oeTerm[i]),
      .pinIn        (pinIn[i]),
      .preloadData  (preloadData[i]),
      .pinDrive     (pinDrive[i]),
      .pinEnable    (pinEnable[i]),
      .arrayFeedback(arrayFeedback[i])
    );
  end

  if (CFG_W != CELLS * 4) begin : g_bad_cfg
    $error("configuration width must be four bits per cell");
  end
endmodule

// File: rtl/macrocell_bank_checker.sv
`timescale 1ns/1ps
module macrocell_bank_checker #(
  parameter int CELLS = 4
) (
  input logic               clkA,
  input logic               powerUpRst,
  input logic               asyncClear,
  input logic               syncPreset,
  input logic               preloadStrobe,
  input logic               secureLock,
  input logic [4*CELLS-1:0] cfgBits,
  input logic [CELLS-1:0]   sumTerm,
  input logic [CELLS-1:0]   oeTerm,
  input logic [CELLS-1:0]   pinIn,
  input logic [CELLS-1:0]   preloadData,
  input logic [CELLS-1:0]   pinDrive,
  input logic [CELLS-1:0]   pinEnable,
  input logic [CELLS-1:0]   arrayFeedback
);
  for (genvar i = 0; i < CELLS; i++) begin : g_chk
    localparam int B = 4 * i;

    assert_comb_follow_R1: assert property (@(posedge clkA) disable iff (powerUpRst)
      cfgBits[B+1] |-> (pinDrive[i] == (sumTerm[i] ^ ~cfgBits[B])));

    assert_reg_load_R2: assert property (@(posedge clkA) disable iff (powerUpRst || asyncClear)
      (cfgBits[B+2] && !syncPreset && !(preloadStrobe && !secureLock))
      |=> (cfgBits[B+1] || (pinDrive[i] == ($past(sumTerm[i]) ^ ~cfgBits[B]))));

    assert_feedback_pin_R5: assert property (@(posedge clkA) disable iff (powerUpRst)
      (cfgBits[B+3] == cfgBits[B+1]) |-> (arrayFeedback[i] == pinIn[i]));

    assert_clear_level_R6: assert property (@(posedge clkA) disable iff (powerUpRst)
      (asyncClear && !cfgBits[B+1]) |-> (pinDrive[i] == ~cfgBits[B]));

    assert_preset_high_R7: assert property (@(posedge clkA) disable iff (powerUpRst || asyncClear)
      (cfgBits[B+2] && syncPreset && !(preloadStrobe && !secureLock))
      |=> (cfgBits[B+1] || (pinDrive[i] == cfgBits[B])));

    assert_clear_wins_R8: assert property (@(posedge clkA) disable iff (powerUpRst)
      (asyncClear && syncPreset && (cfgBits[B+3] != cfgBits[B+1])) |-> (arrayFeedback[i] == 1'b0));

    assert_preload_R9: assert property (@(posedge clkA) disable iff (powerUpRst || asyncClear)
      (cfgBits[B+2] && preloadStrobe && !secureLock)
      |=> (cfgBits[B+1] || (pinDrive[i] == ($past(preloadData[i]) ^ ~cfgBits[B]))));

    assert_enable_R11: assert property (@(posedge clkA) disable iff (powerUpRst)
      pinEnable[i] == oeTerm[i]);
  end
endmodule

bind macrocell_bank macrocell_bank_checker #(.CELLS(CELLS)) bankChecker (
  .clkA(clkA), .powerUpRst(powerUpRst), .asyncClear(asyncClear),
  .syncPreset(syncPreset), .preloadStrobe(preloadStrobe), .secureLock(secureLock),
  .cfgBits(cfgBits), .sumTerm(sumTerm), .oeTerm(oeTerm), .pinIn(pinIn),
  .preloadData(preloadData), .pinDrive(pinDrive), .pinEnable(pinEnable),
  .arrayFeedback(arrayFeedback)
);

// File: tb/macrocell_bank_test.sv
`timescale 1ns/1ps
module macrocell_bank_test;
  localparam int CELLS = 3;
  localparam int WATCHDOG_NS = 200000 * 8;

  logic clkA = 1'b0, clkB = 1'b0;
  logic powerUpRst, asyncClear, syncPreset, preloadStrobe, secureLock;
  logic [4*CELLS-1:0] cfgBits;
  logic [CELLS-1:0] sumTerm, oeTerm, pinIn, preloadData;
  logic [CELLS-1:0] pinDrive, pinEnable, arrayFeedback;

  int checks = 0;
  int errors = 0;
  bit finished = 0;

  macrocell_bank #(.CELLS(CELLS)) uut (
    .clkA(clkA), .clkB(clkB), .powerUpRst(powerUpRst), .asyncClear(asyncClear),
    .syncPreset(syncPreset), .preloadStrobe(preloadStrobe), .secureLock(secureLock),
    .cfgBits(cfgBits), .sumTerm(sumTerm), .oeTerm(oeTerm), .pinIn(pinIn),
    .preloadData(preloadData), .pinDrive(pinDrive), .pinEnable(pinEnable),
    .arrayFeedback(arrayFeedback)
  );

  always #4 clkA = ~clkA;              // 125 MHz
  initial begin #10; forever #8 clkB = ~clkB; end

  // reference model of each cell's flip-flop
  logic [CELLS-1:0] qModel = '0;
  logic prevA = 1'b0, prevB = 1'b0;

  function automatic logic nextState(int i);
    if (preloadStrobe && !secureLock) return preloadData[i];
    if (syncPreset) return 1'b1;
    return sumTerm[i];
  endfunction

  always @(clkA or clkB or asyncClear or powerUpRst) begin
    logic riseA, riseB;
    riseA = clkA && !prevA;
    riseB = clkB && !prevB;
    prevA = clkA;
    prevB = clkB;
    for (int i = 0; i < CELLS; i++) begin
      if (asyncClear || powerUpRst) qModel[i] = 1'b0;
      else if ((riseA && cfgBits[4*i+2]) || (riseB && !cfgBits[4*i+2]))
        qModel[i] = nextState(i);
    end
  end

  task automatic check1(string req, string what, logic act, logic exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s actual=%0b expected=%0b at %0t", req, what, act, exp, $time);
    end
  endtask

  task automatic checkAll();
    for (int i = 0; i < CELLS; i++) begin
      logic s0, s1, s3, pre;
      s0 = cfgBits[4*i]; s1 = cfgBits[4*i+1]; s3 = cfgBits[4*i+3];
      pre = s1 ? sumTerm[i] : qModel[i];
      check1(s1 ? "R1,R3" : "R2,R3", $sformatf("pinDrive[%0d]", i), pinDrive[i], s0 ? pre : ~pre);
      check1("R5", $sformatf("arrayFeedback[%0d]", i), arrayFeedback[i], (s3 == s1) ? pinIn[i] : qModel[i]);
      check1("R11", $sformatf("pinEnable[%0d]", i), pinEnable[i], oeTerm[i]);
    end
  endtask

  task automatic settle();
    #1;
    checkAll();
  endtask

  task automatic finish();
    if (!finished) begin
      finished = 1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  endtask

  initial begin
    #(WATCHDOG_NS);
    errors++;
    $display("FAIL watchdog expired");
    finish();
  end

  initial begin
    void'($urandom(32'h1A2B3C4D));
    powerUpRst = 1; asyncClear = 0; syncPreset = 0; preloadStrobe = 0; secureLock = 0;
    sumTerm = '0; oeTerm = '1; pinIn = '0; preloadData = '0;
    // cell0 reg active-low clkA, cell1 reg active-high clkA, cell2 reg active-high clkB
    cfgBits = {4'b1001, 4'b1101, 4'b1100};
    @(negedge clkA); settle();
    check1("R6", "power-up active-low pin", pinDrive[0], 1'b1);
    check1("R6", "power-up active-high pin", pinDrive[1], 1'b0);

    @(negedge clkA); powerUpRst = 0; sumTerm = 3'b011; settle();
    @(negedge clkA); settle();
    check1("R2", "registered sum loads cell1", pinDrive[1], 1'b1);

    // preset
    @(negedge clkA); sumTerm = '0; syncPreset = 1; settle();
    @(negedge clkA); syncPreset = 0; settle();
    check1("R7", "preset active-low pin", pinDrive[0], 1'b0);
    check1("R7", "preset active-high pin", pinDrive[1], 1'b1);

    // clear beats preset
    @(negedge clkA); asyncClear = 1; syncPreset = 1; sumTerm = '1; settle();
    check1("R6", "immediate clear", pinDrive[1], 1'b0);
    @(negedge clkA); settle();
    check1("R8", "clear held over preset edge", pinDrive[1], 1'b0);
    check1("R8", "clear held register feedback", arrayFeedback[1], 1'b0);
    @(negedge clkA); asyncClear = 0; syncPreset = 0; sumTerm = '0; settle();

    // preload allowed
    @(negedge clkA); preloadData = '1; preloadStrobe = 1; syncPreset = 1; settle();
    @(negedge clkA); preloadStrobe = 0; syncPreset = 0; preloadData = '0; settle();
    check1("R9", "preload over preset and sum", pinDrive[1], 1'b1);
    check1("R9", "preload into active-low cell", pinDrive[0], 1'b0);
    @(negedge clkA); settle();

    // preload locked
    @(negedge clkA); secureLock = 1; preloadData = '1; preloadStrobe = 1; settle();
    @(negedge clkA); preloadStrobe = 0; preloadData = '0; settle();
    check1("R10", "locked preload ignored", pinDrive[1], 1'b0);
    check1("R10", "locked preload feedback", arrayFeedback[1], 1'b0);
    secureLock = 0;

    // clock selection on cell2
    @(posedge clkB); #1; sumTerm[2] = 0;
    @(posedge clkB); #1; sumTerm[2] = 1;
    @(posedge clkA); #1;
    check1("R4", "clkA edge ignored by clkB cell", pinDrive[2], 1'b0);
    @(posedge clkB); #1;
    check1("R4", "clkB edge loads clkB cell", pinDrive[2], 1'b1);
    sumTerm[2] = 0;

    // unprogrammed cell and dedicated input
    @(negedge clkA); asyncClear = 1; cfgBits[3:0] = 4'b1111; cfgBits[7:4] = 4'b0001; settle();
    @(negedge clkA); asyncClear = 0; sumTerm[0] = 1; pinIn = 3'b010; oeTerm = 3'b101; settle();
    check1("R12", "default cfg comb active-high", pinDrive[0], 1'b1);
    check1("R12", "default cfg pin feedback", arrayFeedback[0], 1'b0);
    check1("R11", "dedicated input enable off", pinEnable[1], 1'b0);
    check1("R11", "dedicated input feedback", arrayFeedback[1], 1'b1);
    @(negedge clkA); sumTerm[0] = 0; pinIn = 3'b001; settle();
    check1("R12", "default cfg comb low", pinDrive[0], 1'b0);
    check1("R11", "dedicated input feedback low", arrayFeedback[1], 1'b0);

    // constrained random phase
    for (int cyc = 0; cyc < 3000; cyc++) begin
      @(negedge clkA);
      if (cyc % 40 == 0) begin
        asyncClear = 1;
        cfgBits = 12'($urandom);
      end else begin
        asyncClear = ($urandom_range(0, 19) == 0);
      end
      sumTerm       = CELLS'($urandom);
      oeTerm        = CELLS'($urandom);
      pinIn         = CELLS'($urandom);
      preloadData   = CELLS'($urandom);
      syncPreset    = ($urandom_range(0, 7) == 0);
      preloadStrobe = ($urandom_range(0, 7) == 0);
      secureLock    = ($urandom_range(0, 2) == 0);
      settle();
    end

    finish();
  end
endmodule